// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM of 256K words by 8 bits. The host side is a request/ready handshake: the host presents an address, write data and a read/write flag together with a request. The controller takes them while it is idle and returns a one-cycle completion pulse. On a read, the word fetched from memory is presented alongside that pulse.

On the memory side the controller drives:
- two chip selects of opposite polarity (an active-low first select and an active-high second select);
- an active-low write strobe;
- an active-low output enable;
- the address;
- a tri-state 8-bit data bus.

One cycle counter times every phase. The read access time, the write-strobe width and the bus turnaround are parameters given in clock cycles. The memory stores a word when its strobe deasserts. The controller therefore raises the write strobe while both selects are still active, so the strobe edge is the one that latches the data. It keeps the output enable high for the whole write and drives the bus only after a turnaround wait, so the bus is never driven by both sides at once.

Top module: `sram_async_ctrl`

## Requirements
- R1: While idle, and after reset, the memory is deselected and `ready_o` is 1. Deselected means `sel_n_o`=1 and `sel_o`=0. In this state `wstb_n_o`=1, `oen_o`=1 and `done_o`=0.
- R2: A read keeps both selects active, the write strobe high and `oen_o` low for exactly RD_CYC cycles. The value on `mem_dq` in the last of those cycles is registered into `rdata_o`. `rdata_o` changes only in the cycle where `done_o` is 1.
- R3: A write has three phases, all with both selects active. First come TURN_CYC cycles with the strobe high and the bus released. Then `wstb_n_o` is low for exactly WR_CYC cycles while the controller drives the bus with the write data. Then comes one cycle with the strobe high.
- R4: `oen_o` is never low while `wstb_n_o` is low or while the controller drives the bus.
- R5: `mem_addr_o` stays constant for every cycle in which the memory is selected. It equals the address accepted with the request.
- R6: Each operation ends with `done_o` high for exactly one cycle, and `ready_o` returns to 1 in that cycle. While an operation is in progress, `ready_o` is 0 and requests are ignored.
- R7: A word written to an address is returned by a later read of that address until that address is written again.
- R8: The controller drives `mem_dq` only while the write strobe is low and in the one cycle after it rises. In that hold cycle the bus still carries the write data and both selects are still active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, taken when `ready_o` is 1 |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host word address |
| wdata_i | input | DATA_W | Host write data |
| ready_o | output | 1 | Controller idle and able to take a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Registered read data |
| mem_addr_o | output | ADDR_W | Memory address |
| sel_n_o | output | 1 | First chip select, active low |
| sel_o | output | 1 | Second chip select, active high |
| wstb_n_o | output | 1 | Write strobe, active low |
| oen_o | output | 1 | Output enable, active low |
| mem_dq | inout | DATA_W | Bidirectional memory data bus |

## Verification
The bench builds the controller with a 10-bit address, RD_CYC=4, WR_CYC=3 and TURN_CYC=2. The narrow address lets the bench hold a full mirror of the memory, so both ends of the address range and read-back after overwrites are checked. The short counts mean every phase boundary (first and last cycle of turnaround, strobe and access) is crossed many times within the run. With these counts, exact-length checks on each phase catch a counter that is off by one.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int RD_CYC   = 7,
  parameter int WR_CYC   = 6,
  parameter int TURN_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              sel_n_o,
  output logic              sel_o,
  output logic              wstb_n_o,
  output logic              oen_o,
  inout  wire  [DATA_W-1:0] mem_dq
);
  localparam int MAX_CYC = (RD_CYC > WR_CYC) ? ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC)
                                             : ((WR_CYC > TURN_CYC) ? WR_CYC : TURN_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSET, S_WPUL, S_WHLD} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] wdata_q;
  logic             drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      done_o     <= 1'b0;
      rdata_o    <= '0;
      mem_addr_o <= '0;
      wdata_q    <= '0;
    end else begin
      done_o <= 1'b0;
      cnt    <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (req_i) begin
            mem_addr_o <= addr_i;
            wdata_q    <= wdata_i;
            st         <= wr_i ? S_WSET : S_RD;
          end
        end
        S_RD:
          if (cnt == RD_LAST) begin
            rdata_o <= mem_dq;
            done_o  <= 1'b1;
            st      <= S_IDLE;
          end
        S_WSET:
          if (cnt == TURN_LAST) begin
            cnt <= '0;
            st  <= S_WPUL;
          end
        S_WPUL:
          if (cnt == WR_LAST) begin
            cnt <= '0;
            st  <= S_WHLD;
          end
        S_WHLD: begin
          done_o <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready_o  = (st == S_IDLE);
  assign sel_n_o  = (st == S_IDLE);
  assign sel_o    = (st != S_IDLE);
  assign wstb_n_o = (st != S_WPUL);
  assign oen_o    = (st != S_RD);
  assign drive    = (st == S_WPUL) || (st == S_WHLD);
  assign mem_dq   = drive ? wdata_q : {DATA_W{1'bz}};

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (sel_n_o && !sel_o && wstb_n_o && oen_o));
  // R2
  rdata_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_o) |-> done_o);
  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oen_o |-> (wstb_n_o && !drive));
  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n_o && $past(!sel_n_o)) |-> $stable(mem_addr_o));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && wstb_n_o) |-> ($past(!wstb_n_o) && !sel_n_o));
endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
  localparam int AW = 10, DW = 8, RDC = 4, WRC = 3, TRC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, done, sel_n, sel, wstb_n, oen;
  logic [DW-1:0] rdata;
  logic [AW-1:0] maddr;
  wire  [DW-1:0] dq;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [DW-1:0] mem    [0:(1<<AW)-1];
  logic [DW-1:0] mirror [0:(1<<AW)-1];

  always #4 clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RDC), .WR_CYC(WRC), .TURN_CYC(TRC)) i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .done_o(done), .rdata_o(rdata), .mem_addr_o(maddr),
    .sel_n_o(sel_n), .sel_o(sel), .wstb_n_o(wstb_n), .oen_o(oen), .mem_dq(dq));

  assign dq = (!sel_n && sel && !oen && wstb_n) ? mem[maddr] : {DW{1'bz}};
  always @(posedge wstb_n) if (!sel_n && sel) mem[maddr] <= dq;

  function automatic int exp_strobe_cycles(input bit w);
    return w ? WRC : 0;
  endfunction
  function automatic int exp_oe_cycles(input bit w);
    return w ? 0 : RDC;
  endfunction

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic run_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int oe_cnt = 0, we_cnt = 0, turn_cnt = 0, n = 0;
    bit seen_we = 0, hold_seen = 0, addr_ok = 1, busy_ok = 1, prev_we_low = 0;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b1; wr = ~w; addr = ~a; wdata = ~d;   // R6: ignored while busy
    while (!done && n < 100) begin
      if (n == 1) req = 1'b0;
      if (ready) busy_ok = 0;
      if (!sel_n && maddr != a) addr_ok = 0;
      if (!oen && (!wstb_n)) check(0, "R4 oe low during strobe", 0, 1);
      if (!oen) oe_cnt++;
      if (!wstb_n) begin
        we_cnt++; seen_we = 1;
        check(dq == d, "R3 bus data during strobe", int'(dq), int'(d));
      end
      if (!sel_n && wstb_n && oen && !seen_we) turn_cnt++;
      if (prev_we_low && wstb_n) begin
        hold_seen = 1;
        check(dq == d && !sel_n && sel, "R8 hold cycle data/selects", int'(dq), int'(d));
      end
      prev_we_low = !wstb_n;
      n++;
      @(negedge clk);
    end
    req = 1'b0;
    check(done, "R6 done reached", int'(done), 1);
    check(busy_ok, "R6 ready low while busy", int'(busy_ok), 1);
    check(addr_ok, "R5 address stable", int'(maddr), int'(a));
    check(ready && sel_n && !sel, "R1 idle after done", int'(ready), 1);
    check(oe_cnt == exp_oe_cycles(w), "R2 oe low cycles", oe_cnt, exp_oe_cycles(w));
    check(we_cnt == exp_strobe_cycles(w), "R3 strobe low cycles", we_cnt, exp_strobe_cycles(w));
    if (w) begin
      check(turn_cnt == TRC, "R3 turnaround cycles", turn_cnt, TRC);
      check(hold_seen, "R8 hold cycle present", int'(hold_seen), 1);
      mirror[a] = d;
    end else begin
      check(rdata == mirror[a], "R7 read data", int'(rdata), int'(mirror[a]));
    end
    @(negedge clk);
    check(!done, "R6 done one cycle", int'(done), 0);
  endtask

  initial begin
    #(8 * 100000);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i] = '0;
      mirror[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(ready && sel_n && !sel && wstb_n && oen && !done, "R1 reset state", int'(ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && sel_n && !sel && wstb_n && oen, "R1 idle after reset", int'(sel_n), 1);
    run_op(1'b1, '0, 8'hA5);
    run_op(1'b1, '1, 8'h3C);
    run_op(1'b0, '0, 8'h00);
    run_op(1'b0, '1, 8'h00);
    run_op(1'b1, 10'h155, 8'hFF);
    run_op(1'b1, 10'h155, 8'h01);
    run_op(1'b0, 10'h155, 8'h00);
    run_op(1'b0, 10'h2AA, 8'h00);
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] ra = AW'($urandom);
      logic [DW-1:0] rd = DW'($urandom);
      run_op(1'($urandom), ra, rd);
    end
    for (int i = 0; i < 16; i++) run_op(1'b0, AW'(i * 61), 8'h00);
    summary();
  end
endmodule